// File: doc/BRIEF.md
# DMA Interrupt Status Aggregator

This block keeps the interrupt status of an Ethernet-style DMA engine. The transmit and receive engines send single-cycle event pulses. Each pulse sets a sticky status bit, and the bit stays set until software writes 1 to its position. An enable register masks the status bits. The enabled status bits feed two summary flags, one for normal events and one for abnormal events. Either summary flag drives the single interrupt output.

A fatal bus error sets its own status bit and latches a 3-bit error type code. It also raises a halt output, which stops the DMA engines until the bit is cleared. The status word also shows a registered copy of the receive engine's process state.

Software uses a small port to read and write the two registers. Address 0 is the status word and address 1 is the enable word. Reads are combinational. Writes take effect at the clock edge.

Top module: `dma_irq_status`

## Requirements
- R1: Status bit 16 (normal summary) is 1 exactly when at least one of bits 0, 2, 6 and 14 is set together with its enable bit.
- R2: Status bit 15 (abnormal summary) is 1 exactly when at least one of bits 1, 3, 4, 5, 7, 8, 9, 10 and 13 is set together with its enable bit.
- R3: A write to address 0 clears each source bit whose write-data bit is 1 and leaves bits written with 0 unchanged. Bits 11 and 12 are not source bits: they always read 0, and events on them are ignored.
- R4: When an event and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R5: A receive-done event on bit 6 clears the early-receive bit 14 at the same edge that sets bit 6. If a bit 14 event arrives in that same cycle, bit 14 stays set.
- R6: An event on bit 13 sets bit 13 and latches the error type input into status bits [25:23]. The latched code holds until the next bus error or a reset. halt_o stays 1 from the edge that sets bit 13 until bit 13 is cleared or the block is reset.
- R7: irq_o is the OR of the normal and abnormal summary bits.
- R8: The enable register at address 1 reads back the written value, masked to the source bit positions (mask 0x067FF).
- R9: Status bits [19:17] show the receive state input, delayed by one clock. The codes are 0 stopped, 1 fetching a descriptor, 3 waiting for a packet, 4 suspended with no descriptor, 5 closing a descriptor and 7 moving data to host memory. Codes 2 and 6 are reserved.
- R10: Reset clears all status bits, all enable bits, the error type code and the receive state field. It also drives irq_o and halt_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 17 | Event pulses, one per status bit position |
| bus_err_type_i | input | 3 | Error type code, sampled when a bit 13 event occurs |
| rx_state_i | input | 3 | Receive engine process state |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 status, 1 enable |
| reg_wdata_i | input | 17 | Write data |
| reg_rdata_o | output | 32 | Read data for the selected register |
| irq_o | output | 1 | Interrupt request |
| halt_o | output | 1 | DMA halt after a fatal bus error |

## Verification
A sticky bit that is lost or stuck shows up at reg_rdata_o on the first read after the edge where the event or clear took effect. If that bit is enabled, irq_o shows the fault in the same cycle. A wrong mask assignment shows up as the wrong summary bit being set. The vectors therefore enable the normal and abnormal groups separately. The bench samples every check one edge after the stimulus, so a one-cycle latency error is also reported. Faults in the early-receive clear and in set-over-clear priority are caught by the same-cycle collision vectors.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int STAT_W   = 17;
  localparam int TX_DONE  = 0;
  localparam int RX_DONE  = 6;
  localparam int BUS_ERR  = 13;
  localparam int EARLY_RX = 14;
  localparam int ABN_SUM  = 15;
  localparam int NORM_SUM = 16;
  localparam int RX_LSB   = 17;
  localparam int ERR_LSB  = 23;

  localparam logic [STAT_W-1:0] NORM_MASK = 17'h04045;
  localparam logic [STAT_W-1:0] ABN_MASK  = 17'h027BA;
  localparam logic [STAT_W-1:0] SRC_MASK  = NORM_MASK | ABN_MASK;

  typedef enum logic [2:0] {
    RX_STOP  = 3'd0,
    RX_FETCH = 3'd1,
    RX_WAIT  = 3'd3,
    RX_SUSP  = 3'd4,
    RX_CLOSE = 3'd5,
    RX_XFER  = 3'd7
  } rx_state_e;
endpackage

// File: rtl/irq_sticky_bits.sv
module irq_sticky_bits #(
  parameter int W = 17
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] hw_clr_i,
  output logic [W-1:0] stat_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic q;
    // set has priority over both clears
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= set_i[i] | (q & ~clr_i[i] & ~hw_clr_i[i]);
    end
    assign stat_o[i] = q;

    // R4
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> q);
    // R3
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q && !clr_i[i] && !hw_clr_i[i]) |=> q);
    // R5
    hw_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hw_clr_i[i] && !set_i[i]) |=> !q);
  end
endmodule

// File: rtl/irq_summary.sv
module irq_summary
  import dma_irq_pkg::*;
(
  input  logic [STAT_W-1:0] stat_i,
  input  logic [STAT_W-1:0] en_i,
  output logic              norm_o,
  output logic              abn_o
);
  logic [STAT_W-1:0] act;
  assign act    = stat_i & en_i;
  assign norm_o = |(act & NORM_MASK);
  assign abn_o  = |(act & ABN_MASK);
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
  import dma_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ERR_W  = 3,
  parameter int RXS_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] evt_i,
  input  logic [ERR_W-1:0]  bus_err_type_i,
  input  logic [RXS_W-1:0]  rx_state_i,
  input  logic              reg_we_i,
  input  logic              reg_addr_i,
  input  logic [STAT_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              halt_o
);
  localparam logic ADDR_STAT = 1'b0;
  localparam logic ADDR_EN   = 1'b1;

  logic [STAT_W-1:0] set, clr, hw_clr, stat, en_q;
  logic [ERR_W-1:0]  err_q;
  logic [RXS_W-1:0]  rx_q;
  logic              norm, abn;

  assign set = evt_i & SRC_MASK;
  assign clr = (reg_we_i && reg_addr_i == ADDR_STAT) ? (reg_wdata_i & SRC_MASK) : '0;

  always_comb begin
    hw_clr           = '0;
    hw_clr[EARLY_RX] = set[RX_DONE];
  end

  irq_sticky_bits #(.W(STAT_W)) u_bits (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set),
    .clr_i    (clr),
    .hw_clr_i (hw_clr),
    .stat_o   (stat)
  );

  irq_summary u_sum (
    .stat_i (stat),
    .en_i   (en_q),
    .norm_o (norm),
    .abn_o  (abn)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      err_q <= '0;
      rx_q  <= RXS_W'(RX_STOP);
    end else begin
      if (reg_we_i && reg_addr_i == ADDR_EN) en_q <= reg_wdata_i & SRC_MASK;
      if (set[BUS_ERR]) err_q <= bus_err_type_i;
      rx_q <= rx_state_i;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_EN) begin
      reg_rdata_o[STAT_W-1:0] = en_q;
    end else begin
      reg_rdata_o[STAT_W-1:0]             = stat & SRC_MASK;
      reg_rdata_o[ABN_SUM]                = abn;
      reg_rdata_o[NORM_SUM]               = norm;
      reg_rdata_o[RX_LSB +: RXS_W]        = rx_q;
      reg_rdata_o[ERR_LSB +: ERR_W]       = err_q;
    end
  end

  assign irq_o  = norm | abn;
  assign halt_o = stat[BUS_ERR];

  // R6
  halt_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_o) |-> $past(evt_i[BUS_ERR]));
  // R6
  err_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i[BUS_ERR] |=> err_q == $past(bus_err_type_i));
  // R7
  no_en_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> !irq_o);
  // R9
  rx_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_state_i == RXS_W'(RX_XFER) |=> rx_q == RXS_W'(RX_XFER));
endmodule

// File: tb/dma_irq_status_bench.sv
module dma_irq_status_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [16:0] evt = '0;
  logic [2:0]  err_type = '0;
  logic [2:0]  rx_state = '0;
  logic        we = 0;
  logic        addr = 0;
  logic [16:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, halt;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  dma_irq_status u_dma_irq_status (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .bus_err_type_i(err_type),
    .rx_state_i(rx_state), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .halt_o(halt)
  );

  typedef struct packed {
    logic [16:0] evt;
    logic        we;
    logic        addr;
    logic [16:0] wd;
    logic [16:0] exp;
    logic        irq;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{17'h00000, 1'b1, 1'b1, 17'h067FF, 17'h00000, 1'b0}, // R8 enable all
    '{17'h00001, 1'b0, 1'b0, 17'h00000, 17'h10001, 1'b1}, // R1
    '{17'h00000, 1'b1, 1'b0, 17'h00000, 17'h10001, 1'b1}, // R3 write 0
    '{17'h00000, 1'b1, 1'b0, 17'h00001, 17'h00000, 1'b0}, // R3 write 1
    '{17'h04000, 1'b0, 1'b0, 17'h00000, 17'h14000, 1'b1}, // R1 early rx
    '{17'h00040, 1'b0, 1'b0, 17'h00000, 17'h10040, 1'b1}, // R5
    '{17'h00040, 1'b1, 1'b0, 17'h00040, 17'h10040, 1'b1}, // R4
    '{17'h00000, 1'b1, 1'b0, 17'h00040, 17'h00000, 1'b0}, // R3
    '{17'h00010, 1'b0, 1'b0, 17'h00000, 17'h08010, 1'b1}, // R2
    '{17'h00000, 1'b1, 1'b1, 17'h04045, 17'h00010, 1'b0}, // R2 masked
    '{17'h00004, 1'b0, 1'b0, 17'h00000, 17'h10014, 1'b1}, // R7
    '{17'h00000, 1'b1, 1'b0, 17'h00014, 17'h00000, 1'b0}, // R3
    '{17'h00001, 1'b1, 1'b1, 17'h00000, 17'h00001, 1'b0}, // R1 masked
    '{17'h01800, 1'b1, 1'b0, 17'h01800, 17'h00001, 1'b0}, // R3 non-source
    '{17'h00000, 1'b1, 1'b0, 17'h00001, 17'h00000, 1'b0}, // R3
    '{17'h04040, 1'b0, 1'b0, 17'h00000, 17'h04040, 1'b0}, // R5 collision
    '{17'h00000, 1'b1, 1'b0, 17'h04040, 17'h00000, 1'b0}, // R3
    '{17'h00000, 1'b1, 1'b1, 17'h027BA, 17'h00000, 1'b0}, // R8
    '{17'h00200, 1'b0, 1'b0, 17'h00000, 17'h08200, 1'b1}, // R2
    '{17'h00000, 1'b1, 1'b0, 17'h00200, 17'h00000, 1'b0}  // R2
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [16:0] e, input logic w, input logic a, input logic [16:0] d);
    @(negedge clk);
    evt = e; we = w; addr = a; wdata = d;
    @(posedge clk);
    #1;
    evt = '0; we = 0; wdata = '0;
    addr = 0;
    #1;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #12;
    // R10 reset state
    check("R10 rdata", rdata, 32'h0);
    check("R10 irq", {31'b0, irq}, 32'h0);
    check("R10 halt", {31'b0, halt}, 32'h0);
    @(negedge clk);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].evt, VEC[i].we, VEC[i].addr, VEC[i].wd);
      check($sformatf("R1-table row %0d stat", i), {15'b0, rdata[16:0]}, {15'b0, VEC[i].exp});
      check($sformatf("R7 row %0d irq", i), {31'b0, irq}, {31'b0, VEC[i].irq});
    end

    // R6 bus error, abnormal enabled (0x027BA)
    @(negedge clk);
    rx_state = 3'd5; err_type = 3'd5;
    step(17'h02000, 1'b0, 1'b0, 17'h0);
    check("R6 stat", {15'b0, rdata[16:0]}, 32'h0A000);
    check("R6 halt", {31'b0, halt}, 32'h1);
    check("R6 err type", {29'b0, rdata[25:23]}, 32'h5);
    check("R9 rx state", {29'b0, rdata[19:17]}, 32'h5);
    check("R7 irq", {31'b0, irq}, 32'h1);
    @(negedge clk);
    err_type = 3'd2;
    step(17'h0, 1'b0, 1'b0, 17'h0);
    check("R6 err held", {29'b0, rdata[25:23]}, 32'h5);
    check("R6 halt held", {31'b0, halt}, 32'h1);
    step(17'h0, 1'b1, 1'b0, 17'h02000);
    check("R6 halt cleared", {31'b0, halt}, 32'h0);
    check("R6 err after clear", {29'b0, rdata[25:23]}, 32'h5);

    // R8 enable readback mask
    step(17'h0, 1'b1, 1'b1, 17'h1FFFF);
    addr = 1; #1;
    check("R8 enable readback", rdata, 32'h067FF);
    addr = 0;

    // R9 registered one cycle
    @(negedge clk);
    rx_state = 3'd7;
    #1;
    check("R9 before edge", {29'b0, rdata[19:17]}, 32'h5);
    @(posedge clk); #1;
    check("R9 after edge", {29'b0, rdata[19:17]}, 32'h7);

    // R10 reset mid-run
    step(17'h00001, 1'b0, 1'b0, 17'h0);
    check("R10 pre-reset irq", {31'b0, irq}, 32'h1);
    @(negedge clk);
    rst_n = 0;
    #1;
    check("R10 status cleared", rdata, 32'h0);
    check("R10 irq cleared", {31'b0, irq}, 32'h0);
    addr = 1; #1;
    check("R10 enable cleared", rdata, 32'h0);
    addr = 0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule